// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers seventeen interrupt sources for a small 8-bit processor core and turns them into a single request with a vector address pair. Each source has a sticky request flag. Each of the fifteen maskable sources also has an enable bit that software writes. A global disable flag blocks all maskable sources. Two sources can never be blocked: the reset entry, which is pending when the block leaves reset, and the software break.

A fixed priority encoder picks the winning source. The core takes it with an acknowledge pulse. On that acknowledge the controller latches the winner, sets the disable flag and clears the winner's request flag. The vector pair then stays fixed until the next acknowledge, so the core can fetch it. Stacking and the memory fetch are left to the core.

The block also handles the source conditioning. Five external pins pass through a two-flop synchronizer, and each has a selectable active edge. A key source fires when the AND of the key-port pins set as inputs falls. One slot is shared between the falling edge of a trigger pin and an A-D completion pulse. Serial sources are gated by their function-select inputs.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Slot numbers run from 0 (highest priority) to 16 (lowest). The slots are: 0 reset, 1 ext pin 0, 2 ext pin 1, 3 serial-1 receive, 4 serial-1 transmit, 5 timer X, 6 timer Y, 7 timer 2, 8 timer 3, 9 ext pin 3, 10 ext pin 4, 11 timer 1, 12 ext pin 2, 13 serial-2, 14 key, 15 conversion slot, 16 break. When several sources are pending together, only the lowest-numbered one is accepted.
- R2: After an accepted acknowledge, `vec_lo_o` = 0xFFFC − 2·slot and `vec_hi_o` = `vec_lo_o` + 1. Both hold until the next accepted acknowledge. After reset they point at slot 0.
- R3: A slot from 1 to 15 can raise `irq_req_o` only when its request flag is 1, its enable bit is 1 and `iflag_o` is 0.
- R4: A write on `req_clr_we_i` ANDs bits 1..15 of `req_clr_data_i` into the request flags. A 1 bit leaves the flag unchanged and never sets it. Slots 0 and 16 are not affected.
- R5: The slot-0 flag is 1 when reset ends. The slot-0 and slot-16 flags raise `irq_req_o` whatever the enables and `iflag_o` hold. `brk_i` sets the slot-16 flag.
- R6: An acknowledge taken while `irq_req_o` is 1 sets `iflag_o` and clears the accepted slot's flag at the same clock edge.
- R7: `edge_sel_i[k]` picks the active edge of `ext_pin_i[k]`: 0 means rising, 1 means falling. A pin edge sets its flag at the third clock edge after the pin changes. An edge of the other direction sets nothing. Changing the select bit while the pin is steady can set the flag at the next edge.
- R8: The key flag (slot 14) is set when the AND of `key_port_i` falls. In that AND, bits whose `key_dir_i` bit is 1 (output) count as 1. A change on an output bit sets nothing.
- R9: Slot 15 uses `conv_sel_i`. With 0, it takes a falling edge of `adt_pin_i`, synchronized, so the flag is set at the third edge. With 1, it takes a rising `adc_done_i`, and the flag is set at the next edge. Switching the select can set the flag.
- R10: `periph_evt_i` bits 0 and 1 (serial-1 receive and transmit) count only while `ser1_on_i` is 1. Bit 7 (serial-2) counts only while `ser2_on_i` is 1.
- R11: A `periph_evt_i` bit that is high sets its flag at the next edge (bits 2..6 go to slots 5, 6, 7, 8, 11). If an event and a software clear of the same flag come in the same cycle, the flag ends up set.
- R12: `iflag_o` is 1 after reset. When no acknowledge is taken, `iflag_we_i` loads `iflag_data_i` into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 5 | Asynchronous external pins 0..4 |
| edge_sel_i | input | 5 | Active edge per pin, 1 = falling |
| key_port_i | input | 8 | Key port pin levels |
| key_dir_i | input | 8 | Key port direction, 1 = output |
| adt_pin_i | input | 1 | Asynchronous conversion trigger pin |
| adc_done_i | input | 1 | A-D completion, synchronous |
| conv_sel_i | input | 1 | Slot-15 source, 1 = A-D completion |
| periph_evt_i | input | 8 | Synchronous peripheral event strobes |
| ser1_on_i | input | 1 | Serial-1 function selected |
| ser2_on_i | input | 1 | Serial-2 function selected |
| brk_i | input | 1 | Software break strobe |
| req_clr_we_i | input | 1 | Request-flag clear write |
| req_clr_data_i | input | 17 | Request clear data, 0 clears |
| en_we_i | input | 1 | Enable write |
| en_data_i | input | 17 | Enable bits, slots 1..15 used |
| iflag_we_i | input | 1 | Disable-flag write |
| iflag_data_i | input | 1 | Disable-flag value |
| irq_ack_i | input | 1 | Core acknowledge |
| irq_req_o | output | 1 | Interrupt request to core |
| vec_lo_o | output | 16 | Vector low-byte address |
| vec_hi_o | output | 16 | Vector high-byte address |
| iflag_o | output | 1 | Global disable flag |
| req_o | output | 17 | Request flags |

## Verification
Latencies differ by path. A synchronous event, a write or an acknowledge shows up on the outputs one clock edge after the cycle it is applied in. A pin edge needs three edges: two synchronizer stages and the edge register. The bench drives and samples on the falling clock edge. For every pin path it samples once before the third rising edge, expecting nothing yet, and once after it, expecting the flag. Sticky flags that should stay clear are watched for four cycles, which is longer than the slowest path.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg: slot numbering, widths and the vector arithmetic
// shared by the interrupt controller and its checker.
package irqc_pkg;
    localparam int NSRC     = 17;
    localparam int SLOT_W   = $clog2(NSRC);
    localparam logic [15:0] VEC_TOP = 16'hFFFC;

    localparam int SLOT_RESET = 0;
    localparam int SLOT_BRK   = NSRC - 1;

    // Slots that software may clear and enable (all but reset and break).
    localparam logic [NSRC-1:0] MASKABLE =
        ~((NSRC'(1) << SLOT_RESET) | (NSRC'(1) << SLOT_BRK));

    // Low address of a slot's vector pair; each step down moves by two.
    function automatic logic [15:0] vec_low(input logic [SLOT_W-1:0] slot);
        return VEC_TOP - {10'd0, slot, 1'b0};
    endfunction
endpackage

// File: rtl/irqc_sync.sv
// Module irqc_sync: multi-stage synchronizer for asynchronous pins.
// Assumes each bit is an independent level; reset clears every stage.
module irqc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin value one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
// Module irqc_edge: one-cycle pulse on the active edge of each bit.
// The active edge is rising when inv_i is 0 and falling when it is 1.
// The level is XORed with inv_i, so toggling inv_i can itself make a pulse.
// The history register resets to ones, so no pulse appears right after reset.
module irqc_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] inv_i,
    output logic [W-1:0] pulse_o
);
    logic [W-1:0] x;
    logic [W-1:0] prev_q;

    assign x = lvl_i ^ inv_i;

    // Remember last cycle's polarity-adjusted level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= x;
    end

    assign pulse_o = x & ~prev_q;
endmodule

// File: rtl/irqc_req_bank.sv
// Module irqc_req_bank: sticky request flags and enable bits.
// A set event wins over an acknowledge clear or a software clear in the same cycle.
// Software clears with 0 bits only inside CLEARABLE; enables exist only there.
module irqc_req_bank #(
    parameter int          N         = 17,
    parameter logic [N-1:0] CLEARABLE = '0,
    parameter logic [N-1:0] RST_REQ   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] ack_clr_i,
    input  logic         sw_clr_we_i,
    input  logic [N-1:0] sw_clr_data_i,
    input  logic         en_we_i,
    input  logic [N-1:0] en_data_i,
    output logic [N-1:0] req_o,
    output logic [N-1:0] en_o
);
    logic [N-1:0] sw_kill;

    assign sw_kill = sw_clr_we_i ? (CLEARABLE & ~sw_clr_data_i) : '0;

    // Update request flags: clears first, then new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= RST_REQ;
        else        req_o <= (req_o & ~ack_clr_i & ~sw_kill) | set_i;
    end

    // Load enable bits on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_o <= '0;
        else if (en_we_i) en_o <= en_data_i & CLEARABLE;
    end
endmodule

// File: rtl/irqc_prio.sv
// Module irqc_prio: fixed-priority pick, where the lowest index wins.
// Assumes cand_i already holds masking; idx_o is 0 when nothing is pending.
module irqc_prio #(
    parameter int N  = 17,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the lowest priority upward so the last hit is the winner.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (cand_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module irq_vector_ctrl: seventeen-slot prioritized vectored interrupt controller.
// It conditions the pin and peripheral sources and keeps the request and enable
// flags and the global disable flag. It offers the top pending slot to the core.
// When an acknowledge is taken while the request is up, it latches that slot.
// Assumes periph_evt_i, adc_done_i and the software writes are synchronous to clk.
module irq_vector_ctrl #(
    parameter int KEY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [4:0]                 ext_pin_i,
    input  logic [4:0]                 edge_sel_i,
    input  logic [KEY_W-1:0]           key_port_i,
    input  logic [KEY_W-1:0]           key_dir_i,
    input  logic                       adt_pin_i,
    input  logic                       adc_done_i,
    input  logic                       conv_sel_i,
    input  logic [7:0]                 periph_evt_i,
    input  logic                       ser1_on_i,
    input  logic                       ser2_on_i,
    input  logic                       brk_i,
    input  logic                       req_clr_we_i,
    input  logic [irqc_pkg::NSRC-1:0]  req_clr_data_i,
    input  logic                       en_we_i,
    input  logic [irqc_pkg::NSRC-1:0]  en_data_i,
    input  logic                       iflag_we_i,
    input  logic                       iflag_data_i,
    input  logic                       irq_ack_i,
    output logic                       irq_req_o,
    output logic [15:0]                vec_lo_o,
    output logic [15:0]                vec_hi_o,
    output logic                       iflag_o,
    output logic [irqc_pkg::NSRC-1:0]  req_o
);
    import irqc_pkg::*;

    localparam logic [NSRC-1:0] RST_REQ = NSRC'(1) << SLOT_RESET;

    logic [4:0]        ext_s, ext_pulse;
    logic [KEY_W:0]    kadt_s;
    logic [KEY_W-1:0]  key_s;
    logic              adt_s, key_lvl, conv_lvl;
    logic [1:0]        misc_pulse;
    logic [NSRC-1:0]   set_evt, ack_clr, en_q, cand;
    logic              win_any, take;
    logic [SLOT_W-1:0] win_idx, sel_q;
    logic              iflag_q;

    // Pin conditioning: synchronizers, then polarity-selectable edge detectors.
    irqc_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .d_i(ext_pin_i), .q_o(ext_s));

    irqc_edge #(.W(5)) u_edge_ext (
        .clk(clk), .rst_n(rst_n), .lvl_i(ext_s), .inv_i(edge_sel_i), .pulse_o(ext_pulse));

    irqc_sync #(.W(KEY_W+1), .STAGES(SYNC_STAGES)) u_sync_kadt (
        .clk(clk), .rst_n(rst_n), .d_i({adt_pin_i, key_port_i}), .q_o(kadt_s));

    assign key_s    = kadt_s[KEY_W-1:0];
    assign adt_s    = kadt_s[KEY_W];
    assign key_lvl  = &(key_s | key_dir_i);
    assign conv_lvl = conv_sel_i ? adc_done_i : ~adt_s;

    // Bit 0: key AND falling; bit 1: conversion slot rising.
    irqc_edge #(.W(2)) u_edge_misc (
        .clk(clk), .rst_n(rst_n), .lvl_i({conv_lvl, key_lvl}),
        .inv_i(2'b01), .pulse_o(misc_pulse));

    // Map every conditioned source onto its priority slot.
    always_comb begin
        set_evt     = '0;
        set_evt[1]  = ext_pulse[0];
        set_evt[2]  = ext_pulse[1];
        set_evt[3]  = periph_evt_i[0] & ser1_on_i;
        set_evt[4]  = periph_evt_i[1] & ser1_on_i;
        set_evt[5]  = periph_evt_i[2];
        set_evt[6]  = periph_evt_i[3];
        set_evt[7]  = periph_evt_i[4];
        set_evt[8]  = periph_evt_i[5];
        set_evt[9]  = ext_pulse[3];
        set_evt[10] = ext_pulse[4];
        set_evt[11] = periph_evt_i[6];
        set_evt[12] = ext_pulse[2];
        set_evt[13] = periph_evt_i[7] & ser2_on_i;
        set_evt[14] = misc_pulse[0];
        set_evt[15] = misc_pulse[1];
        set_evt[SLOT_BRK] = brk_i;
    end

    irqc_req_bank #(.N(NSRC), .CLEARABLE(MASKABLE), .RST_REQ(RST_REQ)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_i(set_evt), .ack_clr_i(ack_clr),
        .sw_clr_we_i(req_clr_we_i), .sw_clr_data_i(req_clr_data_i),
        .en_we_i(en_we_i), .en_data_i(en_data_i), .req_o(req_o), .en_o(en_q));

    assign cand = req_o & (~MASKABLE | (en_q & {NSRC{~iflag_q}}));

    irqc_prio #(.N(NSRC), .IW(SLOT_W)) u_prio (
        .cand_i(cand), .any_o(win_any), .idx_o(win_idx));

    assign irq_req_o = win_any;
    assign take      = irq_ack_i & win_any;
    assign ack_clr   = take ? (NSRC'(1) << win_idx) : '0;

    // Global disable flag: acceptance sets it, software writes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          iflag_q <= 1'b1;
        else if (take)       iflag_q <= 1'b1;
        else if (iflag_we_i) iflag_q <= iflag_data_i;
    end

    // Latch the accepted slot so the vector holds during the core's fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= SLOT_W'(SLOT_RESET);
        else if (take) sel_q <= win_idx;
    end

    assign iflag_o  = iflag_q;
    assign vec_lo_o = vec_low(sel_q);
    assign vec_hi_o = VEC_TOP + 16'd1 - {10'd0, sel_q, 1'b0};
endmodule

// File: rtl/irqc_checker.sv
// Module irqc_checker: temporal properties of the interrupt controller,
// attached to every irq_vector_ctrl instance through bind.
module irqc_checker (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      irq_req_o,
    input logic                      irq_ack_i,
    input logic                      iflag_o,
    input logic [15:0]               vec_lo_o,
    input logic [15:0]               vec_hi_o,
    input logic [irqc_pkg::NSRC-1:0] req_o,
    input logic [irqc_pkg::NSRC-1:0] en_q
);
    // R6: an accepted acknowledge leaves the disable flag set.
    a_r6_accept_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_req_o) |=> iflag_o);

    // R2: the vector holds when no acknowledge is taken.
    a_r2_vec_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack_i && irq_req_o) |=> $stable(vec_lo_o));

    // R3: a request comes only from an unmaskable flag or an enabled flag while unmasked.
    a_r3_masking: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (req_o[0] || req_o[16] || (!iflag_o && (|(req_o[15:1] & en_q[15:1])))));

    // R5: a pending break always reaches the core.
    a_r5_brk_unmaskable: assert property (@(posedge clk) disable iff (!rst_n)
        req_o[16] |-> irq_req_o);

    // R1: a pending reset slot wins any acknowledge.
    a_r1_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o[0] && irq_ack_i && irq_req_o) |=> (vec_lo_o == 16'hFFFC));

    // R2: the high address sits one above the low address.
    always @(posedge clk) begin
        if (rst_n) a_r2_vec_pair: assert (vec_hi_o == vec_lo_o + 16'd1);
    end
endmodule

bind irq_vector_ctrl irqc_checker i_chk (
    .clk(clk), .rst_n(rst_n), .irq_req_o(irq_req_o), .irq_ack_i(irq_ack_i),
    .iflag_o(iflag_o), .vec_lo_o(vec_lo_o), .vec_hi_o(vec_hi_o),
    .req_o(req_o), .en_q(en_q));

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ext_pin = '0, edge_sel = '0;
    logic [7:0]  key_port = 8'hFF, key_dir = '0;
    logic        adt_pin = 1'b1, adc_done = 1'b0, conv_sel = 1'b0;
    logic [7:0]  periph = '0;
    logic        ser1_on = 1'b1, ser2_on = 1'b1, brk = 1'b0;
    logic        rc_we = 1'b0, en_we = 1'b0, if_we = 1'b0, if_data = 1'b0, ack = 1'b0;
    logic [16:0] rc_data = '0, en_data = '0;
    logic        irq_req, iflag;
    logic [15:0] vlo, vhi;
    logic [16:0] reqs;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    localparam logic [16:0] EN_ALL = 17'h0FFFE;

    // Table entry: {periph events[7:0], enables[16:0], expected vec_lo[15:0]}
    localparam logic [40:0] TAB [0:7] = '{
        {8'h01, EN_ALL,    16'hFFF6},
        {8'h03, EN_ALL,    16'hFFF6},
        {8'h02, EN_ALL,    16'hFFF4},
        {8'hFC, EN_ALL,    16'hFFF2},
        {8'h80, EN_ALL,    16'hFFE2},
        {8'hC0, EN_ALL,    16'hFFE6},
        {8'h0F, 17'h0FFE6, 16'hFFF2},
        {8'h30, EN_ALL,    16'hFFEE}
    };

    always #4 clk = ~clk;   // 125 MHz

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .edge_sel_i(edge_sel),
        .key_port_i(key_port), .key_dir_i(key_dir), .adt_pin_i(adt_pin),
        .adc_done_i(adc_done), .conv_sel_i(conv_sel), .periph_evt_i(periph),
        .ser1_on_i(ser1_on), .ser2_on_i(ser2_on), .brk_i(brk),
        .req_clr_we_i(rc_we), .req_clr_data_i(rc_data), .en_we_i(en_we),
        .en_data_i(en_data), .iflag_we_i(if_we), .iflag_data_i(if_data),
        .irq_ack_i(ack), .irq_req_o(irq_req), .vec_lo_o(vlo), .vec_hi_o(vhi),
        .iflag_o(iflag), .req_o(reqs));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_req(input logic [16:0] d);
        rc_we = 1'b1; rc_data = d; cyc(1); rc_we = 1'b0;
    endtask

    task automatic set_en(input logic [16:0] d);
        en_we = 1'b1; en_data = d; cyc(1); en_we = 1'b0;
    endtask

    task automatic set_if(input logic v);
        if_we = 1'b1; if_data = v; cyc(1); if_we = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; cyc(1); ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R5 R12 R2: state right after reset
        chk("R5 reset slot pending", 32'(reqs), 32'h1);
        chk("R5 reset requests", 32'(irq_req), 32'h1);
        chk("R12 iflag after reset", 32'(iflag), 32'h1);
        chk("R2 vec after reset", 32'(vlo), 32'hFFFC);
        cyc(4);
        chk("R7 no spurious after reset", 32'(reqs), 32'h1);
        do_ack();
        // R1 R6: reset slot accepted first
        chk("R1 reset vector lo", 32'(vlo), 32'hFFFC);
        chk("R2 reset vector hi", 32'(vhi), 32'hFFFD);
        chk("R6 reset flag cleared", 32'(reqs), 32'h0);
        chk("R6 request drops", 32'(irq_req), 32'h0);

        // R1 R2 R11: table of peripheral event patterns
        for (int i = 0; i < 8; i++) begin
            clr_req(17'h0);
            set_en(TAB[i][32:16]);
            set_if(1'b0);
            periph = TAB[i][40:33]; cyc(1); periph = '0;
            chk("R11 event raises request", 32'(irq_req), 32'h1);
            do_ack();
            chk("R1 winner vector", 32'(vlo), 32'(TAB[i][15:0]));
            chk("R2 vector hi", 32'(vhi), 32'(TAB[i][15:0]) + 32'h1);
            chk("R6 iflag set on accept", 32'(iflag), 32'h1);
        end

        // R6 R2: accepted flag cleared; vector holds when no acknowledge
        clr_req(17'h0);
        set_en(EN_ALL); set_if(1'b0);
        periph = 8'h04; cyc(1); periph = '0;          // slot 5
        do_ack();
        chk("R6 accepted flag cleared", 32'(reqs[5]), 32'h0);
        cyc(3);
        chk("R2 vector held", 32'(vlo), 32'hFFF2);

        // R3: masked by iflag, then by enable
        clr_req(17'h0);
        set_if(1'b1);
        periph = 8'h08; cyc(1); periph = '0;          // slot 6
        chk("R3 flag set while masked", 32'(reqs[6]), 32'h1);
        chk("R3 iflag blocks", 32'(irq_req), 32'h0);
        set_en(17'h0); set_if(1'b0);
        chk("R12 iflag written", 32'(iflag), 32'h0);
        chk("R3 enable blocks", 32'(irq_req), 32'h0);
        set_en(17'h00040);
        chk("R3 enabled and unmasked", 32'(irq_req), 32'h1);

        // R4: writing ones does nothing; zero clears
        clr_req(17'h1FFFF);
        chk("R4 write one keeps flag", 32'(reqs), 32'h00040);
        clr_req(17'h0);
        chk("R4 write zero clears", 32'(reqs), 32'h0);

        // R11: event and clear in the same cycle
        rc_we = 1'b1; rc_data = '0; periph = 8'h04; cyc(1);
        rc_we = 1'b0; periph = '0;
        chk("R11 set wins over clear", 32'(reqs[5]), 32'h1);
        clr_req(17'h0);

        // R5: break ignores masks; loses to a maskable slot on priority
        set_en(17'h0); set_if(1'b1);
        brk = 1'b1; cyc(1); brk = 1'b0;
        chk("R5 brk while masked", 32'(irq_req), 32'h1);
        do_ack();
        chk("R5 brk vector", 32'(vlo), 32'hFFDC);
        chk("R5 brk vector hi", 32'(vhi), 32'hFFDD);
        set_en(EN_ALL); set_if(1'b0);
        brk = 1'b1; periph = 8'h04; cyc(1); brk = 1'b0; periph = '0;
        do_ack();
        chk("R1 maskable beats brk", 32'(vlo), 32'hFFF2);
        chk("R5 brk still requests", 32'(irq_req), 32'h1);
        do_ack();
        chk("R5 brk after", 32'(vlo), 32'hFFDC);
        clr_req(17'h0);

        // R7: rising edge on pin 0, three-edge latency
        ext_pin[0] = 1'b1; cyc(2);
        chk("R7 not yet after two edges", 32'(reqs[1]), 32'h0);
        cyc(1);
        chk("R7 rising pin 0 at third edge", 32'(reqs[1]), 32'h1);
        ext_pin[0] = 1'b0; clr_req(17'h0); cyc(4);
        chk("R7 falling ignored in rising mode", 32'(reqs[1]), 32'h0);
        // Select change on a steady low pin 2 raises slot 12
        edge_sel[2] = 1'b1; cyc(1);
        chk("R7 select change raises", 32'(reqs[12]), 32'h1);
        clr_req(17'h0);
        ext_pin[2] = 1'b1; cyc(4);
        chk("R7 rising ignored in falling mode", 32'(reqs[12]), 32'h0);
        ext_pin[2] = 1'b0; cyc(3);
        chk("R7 falling pin 2", 32'(reqs[12]), 32'h1);
        ext_pin[3] = 1'b1; cyc(3);
        chk("R7 rising pin 3 slot 9", 32'(reqs[9]), 32'h1);
        clr_req(17'h0);

        // R8: key AND with output bits excluded
        key_dir = 8'hF0;
        key_port[7] = 1'b0; cyc(4);
        chk("R8 output bit ignored", 32'(reqs[14]), 32'h0);
        key_port = 8'hFF; cyc(4);
        key_port[2] = 1'b0; cyc(3);
        chk("R8 input bit falls", 32'(reqs[14]), 32'h1);
        key_port = 8'hFF; clr_req(17'h0);

        // R9: conversion slot sources
        adt_pin = 1'b0; cyc(3);
        chk("R9 trigger pin falling", 32'(reqs[15]), 32'h1);
        clr_req(17'h0);
        conv_sel = 1'b1; cyc(2);
        chk("R9 no set on switch to done", 32'(reqs[15]), 32'h0);
        adc_done = 1'b1; cyc(1); adc_done = 1'b0;
        chk("R9 conversion done", 32'(reqs[15]), 32'h1);
        clr_req(17'h0);
        conv_sel = 1'b0; cyc(1);
        chk("R9 switch back raises", 32'(reqs[15]), 32'h1);
        clr_req(17'h0);

        // R10: serial qualification
        ser1_on = 1'b0; ser2_on = 1'b0;
        periph = 8'h83; cyc(1); periph = '0;
        chk("R10 serial events gated", 32'(reqs), 32'h0);
        ser1_on = 1'b1;
        periph = 8'h01; cyc(1); periph = '0;
        chk("R10 serial-1 counts when on", 32'(reqs[3]), 32'h1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule